// File: doc/BRIEF.md
# Serial Single-Precision Divider

This unit divides one 32-bit binary floating-point word by another, one quotient bit per clock. A caller places both operands on the inputs and pulses `start` while the unit is idle. The result word appears together with a one-cycle `done` pulse. Overflow and underflow flags come with it. The result and flags hold until the next result is delivered.

Zero operands are detected before any iteration starts and are answered on the cycle after `start`. An operand counts as zero when its exponent field is 0, whatever its fraction holds, so denormal inputs are flushed to zero. All other operands go through a restoring division of the two 24-bit significands, and the hidden 1 is always included. The quotient is truncated, not rounded. It is then normalized by at most one left shift and packed with the sign and a biased exponent. An exponent field of 255 on an input gets no special treatment; such an operand is divided like any other number.

Top module: `fpdiv_serial`

## Requirements
- R1: While `rst_n` is low at a clock edge, `quotient`, `done`, `overflow` and `underflow` become 0. A reset in the middle of a division abandons it, and no `done` follows.
- R2: If the divisor is zero and the dividend is not, the result is infinity: sign = XOR of the operand signs (bit 31), exponent field (bits 30:23) = 255, fraction (bits 22:0) = 0. Both flags are 0.
- R3: If both operands are zero, the result is the NaN word 0x7FC00000, whatever the operand signs, and both flags are 0.
- R4: If the dividend is zero and the divisor is not, the result is a zero whose sign is the XOR of the operand signs, and both flags are 0.
- R5: For non-zero operands, result bit 31 is the XOR of the operand sign bits.
- R6: For non-zero operands, let Q = floor(Ma * 2^24 / Mb), where Ma and Mb are the 24-bit significands with the hidden 1. If bit 24 of Q is 1, the fraction is Q[23:1]. Otherwise the fraction is Q[22:0].
- R7: For non-zero operands, the exponent field is Ea - Eb + 127, reduced by 1 when bit 24 of Q is 0.
- R8: If the exponent from R7 is 255 or more, the result is an infinity with the R5 sign, and `overflow` is 1.
- R9: If the exponent from R7 is 0 or less, the result is a zero with the R5 sign, and `underflow` is 1.
- R10: `done` is high for exactly one cycle. For the zero cases of R2 to R4 it is high in the cycle after the edge that samples `start`. For non-zero operands it rises 26 clock edges after that edge.
- R11: A `start` that arrives while a division is running is ignored. Exactly one `done` follows, and it carries the result of the first operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a division with the present operands (honoured only when idle) |
| dividend | input | 32 | Numerator word: sign, 8-bit biased exponent, 23-bit fraction |
| divisor | input | 32 | Denominator word, same layout |
| quotient | output | 32 | Result word, held until the next result |
| done | output | 1 | One-cycle pulse when `quotient` is updated |
| overflow | output | 1 | Result exponent reached 255 or more; an infinity was returned |
| underflow | output | 1 | Result exponent fell to 0 or below; a zero was returned |

## Verification
The hardest case to reach is an underflow caused only by the normalizing shift. The biased exponent difference is exactly 1, and the dividend significand is smaller than the divisor significand, so the left shift drops the exponent to 0. The stimulus divides the smallest normal number by 1.5 to get there. It also divides 1 by 1.5, which takes the same shift without any underflow. The second hard case is a `start` pulse in the middle of an iteration. That pulse carries a divide-by-zero, which would be answered at once if it were accepted. The bench then counts the `done` pulses and checks that the result word belongs to the first operation.

// File: rtl/fpdiv_pkg.sv
// Shared constants and types for the serial floating-point divider.
// Assumes a binary interchange layout: sign, biased exponent, fraction.
package fpdiv_pkg;
    parameter int FP_EXP_W  = 8;
    parameter int FP_FRAC_W = 23;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } div_state_t;
endpackage

// File: rtl/fpdiv_special.sv
// Zero-operand classifier. Flags operands whose exponent field is 0 as zero
// and builds the immediate answer: NaN for 0/0, signed infinity for x/0,
// signed zero for 0/x. Assumes the caller only uses the word when special=1.
module fpdiv_special #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WW    = 1 + EXP_W + FRAC_W
) (
    input  logic             a_sign,
    input  logic             b_sign,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [EXP_W-1:0] b_exp,
    output logic             special,
    output logic [WW-1:0]    result
);
    logic a_zero, b_zero, sgn;

    // classify operands and choose the immediate result
    always_comb begin
        a_zero  = (a_exp == '0);
        b_zero  = (b_exp == '0);
        sgn     = a_sign ^ b_sign;
        special = a_zero | b_zero;
        if (a_zero && b_zero)
            result = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
        else if (b_zero)
            result = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else
            result = {sgn, {(WW-1){1'b0}}};
    end
endmodule

// File: rtl/fpdiv_restore.sv
// Restoring significand divider. On load it captures both significands and
// then retires one quotient bit per cycle, SIG_W+1 bits in all, giving
// floor(dvd * 2^SIG_W / dvs). fin pulses in the cycle after the last bit.
// Assumes both significands have their top bit set.
module fpdiv_restore #(
    parameter int SIG_W = 24,
    localparam int QW   = SIG_W + 1,
    localparam int CW   = $clog2(QW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SIG_W-1:0] dvd_sig,
    input  logic [SIG_W-1:0] dvs_sig,
    output logic             fin,
    output logic [QW-1:0]    quo
);
    logic [QW-1:0]    rem;
    logic [SIG_W-1:0] dvs_r;
    logic [CW-1:0]    cnt;
    logic             run;
    logic             ge;
    logic [SIG_W-1:0] diff, keep;

    // trial subtraction; keep the old remainder when it goes negative
    always_comb begin
        ge   = (rem >= {1'b0, dvs_r});
        diff = rem[SIG_W-1:0] - dvs_r;
        keep = ge ? diff : rem[SIG_W-1:0];
    end

    // iteration state: remainder, quotient shift register, bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem   <= '0;
            dvs_r <= '0;
            quo   <= '0;
            cnt   <= '0;
            run   <= 1'b0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                rem   <= {1'b0, dvd_sig};
                dvs_r <= dvs_sig;
                quo   <= '0;
                cnt   <= '0;
                run   <= 1'b1;
            end else if (run) begin
                rem <= {keep, 1'b0};
                quo <= {quo[QW-2:0], ge};
                cnt <= cnt + 1'b1;
                if (cnt == CW'(QW - 1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end

    // R6: the partial remainder never reaches twice the divisor
    a_r6_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (rem < {dvs_r, 1'b0}));
endmodule

// File: rtl/fpdiv_serial.sv
// Serial floating-point divider top. Zero operands are answered in one
// cycle; otherwise sign and exponent are captured, the significands are
// divided bit-serially, and the quotient is normalized (one left shift at
// most), range-checked and packed. Truncates; no rounding, no denormals.
module fpdiv_serial
    import fpdiv_pkg::*;
#(
    parameter int EXP_W  = FP_EXP_W,
    parameter int FRAC_W = FP_FRAC_W,
    localparam int WW    = 1 + EXP_W + FRAC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [WW-1:0] dividend,
    input  logic [WW-1:0] divisor,
    output logic [WW-1:0] quotient,
    output logic          done,
    output logic          overflow,
    output logic          underflow
);
    localparam int SIG_W   = FRAC_W + 1;
    localparam int QW      = SIG_W + 1;
    localparam int XW      = EXP_W + 2;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_TOP = (1 << EXP_W) - 1;
    localparam logic signed [XW-1:0] EXP_TOP_V = XW'(EXP_TOP);

    div_state_t             state;
    logic                   special, load, fin, sign_r, lead;
    logic [WW-1:0]          spec_word;
    logic [QW-1:0]          quo;
    logic signed [XW-1:0]   exp_r, exp_n;
    logic [FRAC_W-1:0]      frac_n;

    fpdiv_special #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_special (
        .a_sign  (dividend[WW-1]),
        .b_sign  (divisor[WW-1]),
        .a_exp   (dividend[WW-2:FRAC_W]),
        .b_exp   (divisor[WW-2:FRAC_W]),
        .special (special),
        .result  (spec_word)
    );

    // launch the iteration only for an accepted, non-zero operation
    always_comb load = (state == ST_IDLE) && start && !special;

    fpdiv_restore #(.SIG_W(SIG_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .dvd_sig ({1'b1, dividend[FRAC_W-1:0]}),
        .dvs_sig ({1'b1, divisor[FRAC_W-1:0]}),
        .fin     (fin),
        .quo     (quo)
    );

    // normalize: shift left once when the leading quotient bit is clear
    always_comb begin
        lead   = quo[QW-1];
        exp_n  = lead ? exp_r : exp_r - {{(XW-1){1'b0}}, 1'b1};
        frac_n = lead ? quo[QW-2:1] : quo[QW-3:0];
    end

    // control, exponent capture, range check and result packing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sign_r    <= 1'b0;
            exp_r     <= '0;
            quotient  <= '0;
            done      <= 1'b0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    if (special) begin
                        quotient  <= spec_word;
                        overflow  <= 1'b0;
                        underflow <= 1'b0;
                        done      <= 1'b1;
                    end else begin
                        sign_r <= dividend[WW-1] ^ divisor[WW-1];
                        exp_r  <= XW'(int'({2'b00, dividend[WW-2:FRAC_W]})
                                    - int'({2'b00, divisor[WW-2:FRAC_W]}) + BIAS);
                        state  <= ST_BUSY;
                    end
                end
                ST_BUSY: if (fin) begin
                    state     <= ST_IDLE;
                    done      <= 1'b1;
                    overflow  <= 1'b0;
                    underflow <= 1'b0;
                    if (exp_n >= EXP_TOP_V) begin
                        quotient <= {sign_r, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                        overflow <= 1'b1;
                    end else if (exp_n[XW-1] || exp_n == '0) begin
                        quotient  <= {sign_r, {(WW-1){1'b0}}};
                        underflow <= 1'b1;
                    end else begin
                        quotient <= {sign_r, exp_n[EXP_W-1:0], frac_n};
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: a finished significand quotient has one of its top two bits set
    a_r6_lead_bit: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (quo[QW-1] | quo[QW-2]));

    // R11: a running division cannot be abandoned by new start pulses
    a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && !fin) |=> (state == ST_BUSY));

    // R8: an overflow result is an infinity
    a_r8_ovf_inf: assert property (@(posedge clk) disable iff (!rst_n)
        (done && overflow) |-> (quotient[WW-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

    // R9: an underflow result is a zero and never overflows at once
    a_r9_unf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && underflow) |-> (quotient[WW-2:0] == '0 && !overflow));
endmodule

// File: tb/sim_fpdiv_serial.sv
`timescale 1ns/1ps
module sim_fpdiv_serial;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] a = '0, b = '0;
    logic [31:0] quotient;
    logic        done, overflow, underflow;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fpdiv_serial u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(a), .divisor(b),
        .quotient(quotient), .done(done),
        .overflow(overflow), .underflow(underflow)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // row: dividend, divisor, expected word, overflow, underflow, zero-case
    localparam int NV = 22;
    localparam logic [98:0] VEC [NV] = '{
        {32'h3F800000, 32'h3F800000, 32'h3F800000, 3'b000},  // R6 R7 1/1
        {32'h40400000, 32'h40000000, 32'h3FC00000, 3'b000},  // R6 3/2
        {32'h3F800000, 32'h40400000, 32'h3EAAAAAA, 3'b000},  // R6 1/3 truncated, shifted
        {32'h3F800000, 32'h3FC00000, 32'h3F2AAAAA, 3'b000},  // R7 shift case 1/1.5
        {32'hC0C00000, 32'h40000000, 32'hC0400000, 3'b000},  // R5 -6/2
        {32'h40000000, 32'hBF000000, 32'hC0800000, 3'b000},  // R5 2/-0.5
        {32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, 3'b000},  // R6 all-ones fraction
        {32'h7F000000, 32'h3F800000, 32'h7F000000, 3'b000},  // R8 exponent 254, no flag
        {32'h7F000000, 32'h3F000000, 32'h7F800000, 3'b100},  // R8 overflow
        {32'hFF000000, 32'h3F000000, 32'hFF800000, 3'b100},  // R8 negative overflow
        {32'h00800000, 32'h40000000, 32'h00000000, 3'b010},  // R9 underflow
        {32'h80800000, 32'h40000000, 32'h80000000, 3'b010},  // R9 negative underflow
        {32'h00800000, 32'h3FC00000, 32'h00000000, 3'b010},  // R9 underflow from shift
        {32'h00800000, 32'h3F800000, 32'h00800000, 3'b000},  // R9 exponent 1, no flag
        {32'h40000000, 32'h00000000, 32'h7F800000, 3'b001},  // R2
        {32'hC0000000, 32'h00000000, 32'hFF800000, 3'b001},  // R2 negative
        {32'h3F800000, 32'h00400000, 32'h7F800000, 3'b001},  // R2 exponent-0 divisor
        {32'h00000000, 32'h00000000, 32'h7FC00000, 3'b001},  // R3
        {32'h80000000, 32'h00000000, 32'h7FC00000, 3'b001},  // R3 signed
        {32'h80000000, 32'h40000000, 32'h80000000, 3'b001},  // R4
        {32'h00000000, 32'hC0000000, 32'h80000000, 3'b001},  // R4 sign
        {32'h00000001, 32'h3F800000, 32'h00000000, 3'b001}   // R4 exponent-0 dividend
    };

    // issue one operation and wait for done; lat = edges after the start edge
    task automatic run_op(input logic [31:0] ai, input logic [31:0] bi,
                          output logic [31:0] q, output logic ov, output logic un,
                          output int lat);
        @(negedge clk);
        a = ai; b = bi; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        lat = 0;
        while (!done && lat < 60) begin
            @(posedge clk); #1;
            lat++;
        end
        q = quotient; ov = overflow; un = underflow;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R10 watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] q;
        logic ov, un;
        int lat;
        int pulses;
        string tag;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset quotient", quotient, 32'h0);
        chk("R1 reset flags", {29'h0, done, overflow, underflow}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [31:0] va, vb, vq;
            logic vov, vun, vsp;
            va = VEC[i][98:67]; vb = VEC[i][66:35]; vq = VEC[i][34:3];
            vov = VEC[i][2]; vun = VEC[i][1]; vsp = VEC[i][0];
            run_op(va, vb, q, ov, un, lat);
            if (vsp)
                tag = (vq == 32'h7FC00000) ? "R3" : (vq[30:23] == 8'hFF) ? "R2" : "R4";
            else if (vov) tag = "R8";
            else if (vun) tag = "R9";
            else tag = "R7";
            chk({tag, " word"}, q, vq);
            chk({tag, " flags"}, {30'h0, ov, un}, {30'h0, vov, vun});
            if (!vsp) begin
                chk("R5 sign", {31'h0, q[31]}, {31'h0, va[31] ^ vb[31]});
                if (!vov && !vun) begin
                    chk("R6 fraction", {9'h0, q[22:0]}, {9'h0, vq[22:0]});
                    chk("R7 exponent", {24'h0, q[30:23]}, {24'h0, vq[30:23]});
                end
            end
            chk("R10 latency", 32'(lat), vsp ? 32'd0 : 32'd26);
            @(posedge clk); #1;
            chk("R10 single pulse", {31'h0, done}, 32'h0);
        end

        // R11: start while busy is ignored
        @(negedge clk);
        a = 32'h3F800000; b = 32'h40400000; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        a = 32'h40000000; b = 32'h00000000; start = 1'b1;
        @(negedge clk); start = 1'b0;
        pulses = 0;
        repeat (40) begin
            @(posedge clk); #1;
            if (done) begin
                pulses++;
                chk("R11 first result kept", quotient, 32'h3EAAAAAA);
            end
        end
        chk("R11 one done", 32'(pulses), 32'd1);

        // R1: reset in the middle of a division
        @(negedge clk);
        a = 32'h40400000; b = 32'h40000000; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (8) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 mid reset quotient", quotient, 32'h0);
        rst_n = 1'b1;
        pulses = 0;
        repeat (40) begin
            @(posedge clk); #1;
            if (done) pulses++;
        end
        chk("R1 abandoned no done", 32'(pulses), 32'd0);

        // R6: a fresh operation after reset still works
        run_op(32'h40400000, 32'h40000000, q, ov, un, lat);
        chk("R6 after reset", q, 32'h3FC00000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule